// File: doc/BRIEF.md
# Serial TDM Highway Timeslot Port

This block sits between a 32-slot serial time-division highway and byte-wide per-channel logic. It runs on the highway bit clock. It finds timeslot 0 from the high-to-low transition of an active-low frame-sync input. After that it tracks the slot and the bit within the slot for every clock.

Received serial bits are gathered into bytes. Each byte is handed out with the number of the slot it came from, and slot n always carries channel n. Transmit bytes are requested one slot before they are needed. A byte supplied for a slot is serialised in that slot on the separate transmit line. A slot with no supplied byte sends an all-ones idle byte.

The frame-sync line may stay low for one slot or for many. Only its falling edge counts. A falling edge that arrives where the counters did not expect it realigns them at once and sets a sticky error flag.

Top module: `pcm_slot_port`

## Requirements
- R1: After reset, `rx_valid`, `tx_req`, `frame_start`, `aligned` and `sync_err` are 0, and `tx_bit` is 1.
- R2: Until the first falling edge of `fsync_n` has been sampled, `rx_valid`, `tx_req` and `frame_start` stay 0 and `tx_bit` stays 1.
- R3: A rising clock edge at which `fsync_n` is sampled low, after it was sampled high at the previous edge, samples bit 0 of slot 0. From the next cycle `aligned` is 1, and `frame_start` is high for exactly that one cycle. How long `fsync_n` then stays low has no effect.
- R4: Each slot is 8 bits and a frame is 32 slots, wrapping from slot 31 to slot 0. While aligned, `cur_chan` gives the slot whose bit is sampled at the next rising edge.
- R5: Receive bits are taken most significant bit first. In the cycle after the edge that samples bit 7 of slot s, `rx_valid` is 1 for one cycle, `rx_byte` holds the 8 bits of slot s, and `rx_chan` equals s.
- R6: Transmit bits go out most significant bit first. During the cycle that ends with the edge sampling bit b of slot s, `tx_bit` holds bit 7-b of the byte for slot s.
- R7: In the cycle after the edge that samples bit 0 of slot s, `tx_req` is 1 for one cycle with `tx_req_chan` = (s+1) mod 32. A byte given on `tx_data` with `tx_load` high at any edge from then up to and including the edge that samples bit 7 of slot s is sent in slot s+1. The last byte loaded wins.
- R8: A slot whose request received no byte sends 0xFF.
- R9: A falling edge of `fsync_n` at any position other than slot 0 bit 0, while aligned, restarts the count at slot 0 bit 0. It sets `sync_err`, which stays 1 until reset. It also discards any staged transmit byte, so the realigned slot 0 sends 1s.
- R10: A falling edge of `fsync_n` exactly at slot 0 bit 0 leaves `sync_err` unchanged and does not disturb transmit data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Highway bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_n | input | 1 | Active-low frame sync; falling edge marks slot 0 |
| rx_bit | input | 1 | Serial receive data |
| tx_load | input | 1 | Strobe: `tx_data` is the byte for the requested slot |
| tx_data | input | 8 | Transmit byte |
| tx_bit | output | 1 | Serial transmit data |
| rx_valid | output | 1 | One-cycle strobe: received byte ready |
| rx_byte | output | 8 | Received byte |
| rx_chan | output | 5 | Channel of the received byte |
| tx_req | output | 1 | One-cycle strobe: supply byte for `tx_req_chan` |
| tx_req_chan | output | 5 | Channel whose transmit byte is requested |
| frame_start | output | 1 | One-cycle pulse at the start of each frame |
| cur_chan | output | 5 | Channel of the bit now on the lines |
| aligned | output | 1 | Frame position known |
| sync_err | output | 1 | Sticky: sync edge seen at an unexpected position |

## Verification
The hardest case to reach is a sync falling edge in the middle of an aligned frame. It must land while a transmit byte is staged or still being scheduled, and the sync line must be high just before it. The stimulus runs the highway model until a chosen slot and bit, well past the longest low period of the sync pulse. It then restarts the model's own position at slot 0 and drives the falling edge there, with a transmit load pending. A second such edge at a random position follows. A directed frame with sync held low for most of the frame shows that the level alone never realigns.

// File: rtl/pcm_slot_port.sv
module pcm_slot_port #(
  parameter int SLOTS     = 32,
  parameter int SLOT_BITS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fsync_n,
  input  logic                     rx_bit,
  input  logic                     tx_load,
  input  logic [SLOT_BITS-1:0]     tx_data,
  output logic                     tx_bit,
  output logic                     rx_valid,
  output logic [SLOT_BITS-1:0]     rx_byte,
  output logic [$clog2(SLOTS)-1:0] rx_chan,
  output logic                     tx_req,
  output logic [$clog2(SLOTS)-1:0] tx_req_chan,
  output logic                     frame_start,
  output logic [$clog2(SLOTS)-1:0] cur_chan,
  output logic                     aligned,
  output logic                     sync_err
);
  localparam int CW = $clog2(SLOTS);
  localparam int BW = $clog2(SLOT_BITS);
  localparam logic [SLOT_BITS-1:0] IDLE = '1;

  logic          fs_q;
  logic [CW-1:0] slot_q;
  logic [BW-1:0] bit_q;
  logic [SLOT_BITS-1:0] rx_sh, tx_cur, tx_stage;
  logic          stage_ok;

  wire at_zero   = (slot_q == '0) && (bit_q == '0);
  wire fall      = fs_q & ~fsync_n;
  wire misfall   = fall & (~aligned | ~at_zero);
  wire live      = aligned | fall;

  wire [CW-1:0] pos_slot  = fall ? '0 : slot_q;
  wire [BW-1:0] pos_bit   = fall ? '0 : bit_q;
  wire          last_bit  = pos_bit == BW'(SLOT_BITS-1);
  wire          last_slot = pos_slot == CW'(SLOTS-1);
  wire [CW-1:0] succ_slot = last_slot ? '0 : pos_slot + 1'b1;
  wire [SLOT_BITS-1:0] rx_word = {rx_sh[SLOT_BITS-2:0], rx_bit};

  assign cur_chan = slot_q;
  assign tx_bit   = ~aligned | tx_cur[BW'(SLOT_BITS-1) - bit_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q     <= 1'b1;
      aligned  <= 1'b0;
      sync_err <= 1'b0;
      slot_q   <= '0;
      bit_q    <= '0;
    end else begin
      fs_q     <= fsync_n;
      aligned  <= aligned | fall;
      sync_err <= sync_err | (fall & aligned & ~at_zero);
      bit_q    <= last_bit ? '0 : pos_bit + 1'b1;
      slot_q   <= last_bit ? succ_slot : pos_slot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh       <= '0;
      rx_valid    <= 1'b0;
      rx_byte     <= '0;
      rx_chan     <= '0;
      tx_req      <= 1'b0;
      tx_req_chan <= '0;
      frame_start <= 1'b0;
    end else begin
      rx_sh       <= rx_word;
      rx_valid    <= live & last_bit;
      tx_req      <= live & (pos_bit == '0);
      frame_start <= live & (pos_bit == '0) & (pos_slot == '0);
      if (live & last_bit) begin
        rx_byte <= rx_word;
        rx_chan <= pos_slot;
      end
      if (live & (pos_bit == '0)) tx_req_chan <= succ_slot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_cur   <= IDLE;
      tx_stage <= IDLE;
      stage_ok <= 1'b0;
    end else if (misfall) begin
      tx_cur   <= IDLE;
      stage_ok <= 1'b0;
    end else if (live & last_bit) begin
      tx_cur   <= tx_load ? tx_data : (stage_ok ? tx_stage : IDLE);
      stage_ok <= 1'b0;
    end else if (tx_load) begin
      tx_stage <= tx_data;
      stage_ok <= 1'b1;
    end
  end
endmodule

module pcm_slot_port_chk #(
  parameter int SLOTS = 32,
  parameter int CW    = $clog2(SLOTS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_bit,
  input logic          rx_valid,
  input logic [CW-1:0] rx_chan,
  input logic          tx_req,
  input logic [CW-1:0] tx_req_chan,
  input logic          frame_start,
  input logic [CW-1:0] cur_chan,
  input logic          aligned,
  input logic          sync_err
);
  // R2
  rx_needs_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> aligned);
  // R2
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned |-> tx_bit);
  // R5
  rx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R5
  rx_chan_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> cur_chan == ((rx_chan == CW'(SLOTS-1)) ? '0 : rx_chan + 1'b1));
  // R7
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> !tx_req);
  // R3
  frame_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> tx_req && cur_chan == '0 && tx_req_chan == CW'(1));
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> sync_err);
  // R3
  align_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aligned |=> aligned);
endmodule

bind pcm_slot_port pcm_slot_port_chk #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_bit(tx_bit), .rx_valid(rx_valid),
  .rx_chan(rx_chan), .tx_req(tx_req), .tx_req_chan(tx_req_chan),
  .frame_start(frame_start), .cur_chan(cur_chan), .aligned(aligned),
  .sync_err(sync_err)
);

// File: tb/tb_pcm_slot_port.sv
`timescale 1ns/1ps
module tb_pcm_slot_port;
  logic clk = 0, rst_n = 0, fsync_n = 1, rx_bit = 0, tx_load = 0;
  logic [7:0] tx_data = 0;
  logic tx_bit, rx_valid, tx_req, frame_start, aligned, sync_err;
  logic [7:0] rx_byte;
  logic [4:0] rx_chan, tx_req_chan, cur_chan;

  pcm_slot_port dut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int ps = 13, pb = 5, lowleft = 0, force_len = 0;
  bit al_m = 0, err_m = 0, fs_prev = 1, sync_on = 0;
  logic [7:0] rxd [32];
  logic [7:0] expt [32];
  bit e_rxv = 0, e_req = 0, e_fs = 0;
  logic [7:0] e_rxb = 0;
  int e_rxc = 0, e_reqc = 0;
  int sup_cnt = -1;
  logic [7:0] sup_data = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cycle(bit inject);
    bit fs, fall_m;
    logic exp_tx;
    @(negedge clk);
    chk(rx_valid == e_rxv, al_m ? "R5" : "R2", "rx_valid", rx_valid, e_rxv);
    if (e_rxv) begin
      chk(rx_byte == e_rxb, "R5", "rx_byte", rx_byte, e_rxb);
      chk(rx_chan == 5'(e_rxc), "R5", "rx_chan", rx_chan, e_rxc);
    end
    chk(tx_req == e_req, al_m ? "R7" : "R2", "tx_req", tx_req, e_req);
    if (e_req) chk(tx_req_chan == 5'(e_reqc), "R7", "tx_req_chan", tx_req_chan, e_reqc);
    chk(frame_start == e_fs, "R3", "frame_start", frame_start, e_fs);
    chk(aligned == al_m, "R3", "aligned", aligned, al_m);
    chk(sync_err == err_m, err_m ? "R9" : "R10", "sync_err", sync_err, err_m);
    if (al_m) chk(cur_chan == 5'(ps), "R4", "cur_chan", cur_chan, ps);
    exp_tx = al_m ? expt[ps][7-pb] : 1'b1;
    chk(tx_bit == exp_tx, (al_m && expt[ps] == 8'hFF) ? "R8" : "R6", "tx_bit", tx_bit, exp_tx);

    if (e_req) begin
      if ($urandom % 4 == 0) expt[e_reqc] = 8'hFF;
      else begin
        sup_cnt = $urandom % 7;
        sup_data = 8'($urandom);
        expt[e_reqc] = sup_data;
      end
    end
    if (inject) begin
      if (al_m && (ps != 0 || pb != 0)) err_m = 1;
      ps = 0; pb = 0;
      expt[0] = 8'hFF;
      sup_cnt = -1;
    end
    tx_load = 0;
    if (sup_cnt == 0) begin
      tx_load = 1;
      tx_data = sup_data;
    end
    if (sup_cnt >= 0) sup_cnt--;

    if (sync_on && ps == 0 && pb == 0)
      lowleft = (force_len != 0) ? force_len : 8 + int'($urandom % 33);
    fs = (lowleft > 0) ? 1'b0 : 1'b1;
    if (lowleft > 0) lowleft--;
    fall_m = fs_prev & ~fs;
    fs_prev = fs;
    fsync_n = fs;
    if (fall_m) al_m = 1;

    if (pb == 0) rxd[ps] = 8'($urandom);
    rx_bit = rxd[ps][7-pb];

    e_rxv = al_m && pb == 7;
    e_rxb = rxd[ps];
    e_rxc = ps;
    e_req = al_m && pb == 0;
    e_reqc = (ps + 1) % 32;
    e_fs = al_m && ps == 0 && pb == 0;

    pb++;
    if (pb == 8) begin
      pb = 0;
      ps = (ps + 1) % 32;
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle(0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) begin
      expt[i] = 8'hFF;
      rxd[i] = 8'h00;
    end
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rx_valid == 0, "R1", "rx_valid", rx_valid, 0);
    chk(tx_req == 0, "R1", "tx_req", tx_req, 0);
    chk(frame_start == 0, "R1", "frame_start", frame_start, 0);
    chk(aligned == 0, "R1", "aligned", aligned, 0);
    chk(sync_err == 0, "R1", "sync_err", sync_err, 0);
    chk(tx_bit == 1, "R1", "tx_bit", tx_bit, 1);

    run(300);
    sync_on = 1;
    run(6 * 256);
    while (!(ps == 0 && pb == 0)) cycle(0);
    force_len = 200;
    run(256);
    force_len = 0;
    run(2 * 256);
    while (!(ps == 9 && pb == 3)) cycle(0);
    cycle(1);
    run(4 * 256);
    begin
      int ts = 6 + int'($urandom % 24);
      int tb = int'($urandom % 8);
      while (!(ps == ts && pb == tb)) cycle(0);
    end
    cycle(1);
    run(3 * 256);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end
endmodule